// File: doc/BRIEF.md
# Dual-Port RAM Busy Arbiter

A two-port synchronous RAM with address-collision busy logic. Each side (left and right) has a chip enable, an address, a write enable, write data and registered read data. Both sides can read at any time, and neither side's traffic slows the other. The only conflict is when both sides are enabled on the same location in the same cycle.

A mode input selects one of two roles. In master mode the block detects a collision and picks the losing side. It drives that side's active-low busy output in the same cycle, and the losing side's write is discarded inside the block. The decision uses only chip enables and addresses; the write enables are not looked at. In slave mode no arbitration takes place. The busy outputs stay inactive and a separate active-low busy input per side acts only as a write inhibit for that side. This lets several slave arrays follow one master's decision.

Top module: `dpram_busy_arb`

## Requirements
- R1: While reset is held, and in the first cycle after it, both busy outputs are high (inactive) and both read data outputs are 0. Every memory word starts at 0.
- R2: In master mode a busy output goes low only when both chip enables are high and the two addresses are equal. In that case exactly one busy output is low.
- R3: The master busy decision ignores the write enables. A collision between two reads drives busy exactly as a collision between two writes does.
- R4: When both sides arrive at the same address in the same cycle, the left side wins and the right busy output goes low.
- R5: A side "holds" an address when it was enabled on that same address in the previous cycle. When exactly one side holds the contested address, the other side gets busy. While both sides stay on the address, the earlier decision is kept.
- R6: In master mode a write from the side whose busy is low is discarded and the word keeps its old value. The winning side's write is stored.
- R7: In slave mode both busy outputs stay high. A side whose busy input is high writes normally. A side whose busy input is low has every write blocked and the word is unchanged.
- R8: Read data appears one clock after a side is enabled. Both sides read concurrently and busy never blocks a read. A read of a word written in the same cycle returns the old value.
- R9: A side with chip enable low has its busy output high, writes nothing, and keeps its previous read data.
- R10: In slave mode, when both sides write the same word in one cycle with both inhibits high, the left data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = busy inputs act as write inhibits |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write enable, active high |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_busy_n_in | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n_out | output | 1 | Left busy indication in master mode, active low |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write enable, active high |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_busy_n_in | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n_out | output | 1 | Right busy indication in master mode, active low |

## Verification
The hardest case to reach from the ports is a late arrival: one side must already sit on an address for at least a cycle before the other side moves onto it. The decision must then hold for as long as both sides stay there. Directed sequences park one side on a word, bring the other side in on the next cycle, and later swap which side leaves and comes back. Randomised traffic in both modes, confined to four addresses, produces many collisions with every kind of history. A behavioural model predicts busy, stored words and read data every cycle, including words whose blocked writes must leave them untouched.

// File: rtl/dpram_busy_pkg.sv
package dpram_busy_pkg;
   // which side lost the current collision (bit1 = left, bit0 = right)
   typedef enum logic [1:0] {
      LOSER_NONE  = 2'b00,
      LOSER_RIGHT = 2'b01,
      LOSER_LEFT  = 2'b10
   } loser_e;

   localparam int SIDE_LEFT  = 0;
   localparam int SIDE_RIGHT = 1;
   localparam int NUM_SIDES  = 2;
endpackage

// File: rtl/dpram_collision_det.sv
module dpram_collision_det #(
   parameter int ADDR_W = 6
) (
   input  logic              l_ce,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_ce,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              hit
);
   logic same_word;

   always_comb begin
      same_word = (l_addr == r_addr);
      hit       = l_ce && r_ce && same_word;
   end
endmodule

// File: rtl/dpram_busy_arbiter.sv
module dpram_busy_arbiter
   import dpram_busy_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_ce,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              hit,
   output logic              busy_l,
   output logic              busy_r
);
   loser_e            tie_loser;
   loser_e            loser_q;
   loser_e            loser_d;
   logic              prev_l_ce;
   logic              prev_r_ce;
   logic [ADDR_W-1:0] prev_l_addr;
   logic [ADDR_W-1:0] prev_r_addr;
   logic              l_held;
   logic              r_held;

   // variant: which side wins a same-cycle arrival
   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_loser = LOSER_RIGHT;
      end else begin : g_tie_right
         assign tie_loser = LOSER_LEFT;
      end
   endgenerate

   always_comb begin
      l_held  = prev_l_ce && (prev_l_addr == l_addr);
      r_held  = prev_r_ce && (prev_r_addr == r_addr);
      loser_d = LOSER_NONE;
      if (hit) begin
         if (l_held && r_held) begin
            loser_d = (loser_q == LOSER_NONE) ? tie_loser : loser_q;
         end else if (l_held) begin
            loser_d = LOSER_RIGHT;
         end else if (r_held) begin
            loser_d = LOSER_LEFT;
         end else begin
            loser_d = tie_loser;
         end
      end
      busy_l = (loser_d == LOSER_LEFT);
      busy_r = (loser_d == LOSER_RIGHT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loser_q     <= LOSER_NONE;
         prev_l_ce   <= 1'b0;
         prev_r_ce   <= 1'b0;
         prev_l_addr <= '0;
         prev_r_addr <= '0;
      end else begin
         loser_q     <= loser_d;
         prev_l_ce   <= l_ce;
         prev_r_ce   <= r_ce;
         prev_l_addr <= l_addr;
         prev_r_addr <= r_addr;
      end
   end
endmodule

// File: rtl/dpram_port_gate.sv
module dpram_port_gate (
   input  logic master_mode,
   input  logic ce,
   input  logic we,
   input  logic busy_int,
   input  logic busy_n_in,
   output logic wr_en,
   output logic busy_n_out
);
   logic allowed;

   always_comb begin
      allowed    = master_mode ? !busy_int : busy_n_in;
      wr_en      = ce && we && allowed;
      busy_n_out = master_mode ? !busy_int : 1'b1;
   end
endmodule

// File: rtl/dpram_mem_core.sv
module dpram_mem_core
   import dpram_busy_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SIDES-1:0]        ce,
   input  logic [NUM_SIDES-1:0]        wr_en,
   input  logic [NUM_SIDES-1:0][ADDR_W-1:0] addr,
   input  logic [NUM_SIDES-1:0][DATA_W-1:0] wdata,
   output logic [NUM_SIDES-1:0][DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // right first, left last: left wins an unarbitrated same-word write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (wr_en[SIDE_RIGHT]) mem[addr[SIDE_RIGHT]] <= wdata[SIDE_RIGHT];
         if (wr_en[SIDE_LEFT])  mem[addr[SIDE_LEFT]]  <= wdata[SIDE_LEFT];
      end
   end

   generate
      for (genvar p = 0; p < NUM_SIDES; p++) begin : g_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata[p] <= '0;
            else if (ce[p]) rdata[p] <= mem[addr[p]];
         end
      end
   endgenerate
endmodule

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb
   import dpram_busy_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_ce,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              l_busy_n_in,
   output logic              l_busy_n_out,
   input  logic              r_ce,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   input  logic              r_busy_n_in,
   output logic              r_busy_n_out
);
   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("dpram_busy_arb: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dpram_busy_arb: DATA_W must be positive");
      end
   endgenerate

   logic                               hit;
   logic [NUM_SIDES-1:0]               busy_int;
   logic [NUM_SIDES-1:0]               ce_v;
   logic [NUM_SIDES-1:0]               we_v;
   logic [NUM_SIDES-1:0]               busy_in_v;
   logic [NUM_SIDES-1:0]               busy_out_v;
   logic [NUM_SIDES-1:0]               wr_en;
   logic [NUM_SIDES-1:0][ADDR_W-1:0]   addr_v;
   logic [NUM_SIDES-1:0][DATA_W-1:0]   wdata_v;
   logic [NUM_SIDES-1:0][DATA_W-1:0]   rdata_v;

   always_comb begin
      ce_v[SIDE_LEFT]       = l_ce;
      ce_v[SIDE_RIGHT]      = r_ce;
      we_v[SIDE_LEFT]       = l_we;
      we_v[SIDE_RIGHT]      = r_we;
      busy_in_v[SIDE_LEFT]  = l_busy_n_in;
      busy_in_v[SIDE_RIGHT] = r_busy_n_in;
      addr_v[SIDE_LEFT]     = l_addr;
      addr_v[SIDE_RIGHT]    = r_addr;
      wdata_v[SIDE_LEFT]    = l_wdata;
      wdata_v[SIDE_RIGHT]   = r_wdata;
   end

   dpram_collision_det #(.ADDR_W(ADDR_W)) u_det (
      .l_ce   (l_ce),
      .l_addr (l_addr),
      .r_ce   (r_ce),
      .r_addr (r_addr),
      .hit    (hit)
   );

   dpram_busy_arbiter #(.ADDR_W(ADDR_W), .TIE_LEFT(TIE_LEFT)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .l_ce   (l_ce),
      .l_addr (l_addr),
      .r_ce   (r_ce),
      .r_addr (r_addr),
      .hit    (hit),
      .busy_l (busy_int[SIDE_LEFT]),
      .busy_r (busy_int[SIDE_RIGHT])
   );

   generate
      for (genvar p = 0; p < NUM_SIDES; p++) begin : g_side
         dpram_port_gate u_gate (
            .master_mode (master_mode),
            .ce          (ce_v[p]),
            .we          (we_v[p]),
            .busy_int    (busy_int[p]),
            .busy_n_in   (busy_in_v[p]),
            .wr_en       (wr_en[p]),
            .busy_n_out  (busy_out_v[p])
         );
      end
   endgenerate

   dpram_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce_v),
      .wr_en (wr_en),
      .addr  (addr_v),
      .wdata (wdata_v),
      .rdata (rdata_v)
   );

   assign l_rdata      = rdata_v[SIDE_LEFT];
   assign r_rdata      = rdata_v[SIDE_RIGHT];
   assign l_busy_n_out = busy_out_v[SIDE_LEFT];
   assign r_busy_n_out = busy_out_v[SIDE_RIGHT];
endmodule

// File: rtl/dpram_busy_arb_chk.sv
module dpram_busy_arb_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_mode,
   input logic              l_ce,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_busy_n_in,
   input logic              l_busy_n_out,
   input logic              r_ce,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_busy_n_in,
   input logic              r_busy_n_out,
   input logic [1:0]        wr_en
);
   logic coll;
   assign coll = l_ce && r_ce && (l_addr == r_addr);

   assert_one_loser_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_n_out && !r_busy_n_out));

   assert_collision_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && coll) |-> (l_busy_n_out != r_busy_n_out));

   assert_no_false_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !coll |-> (l_busy_n_out && r_busy_n_out));

   assert_idle_left_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !l_ce |-> (l_busy_n_out && !wr_en[0]));

   assert_idle_right_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !r_ce |-> (r_busy_n_out && !wr_en[1]));

   assert_tie_left_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && coll && !$past(l_ce) && !$past(r_ce)) |-> !r_busy_n_out);

   assert_decision_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && $past(master_mode) && coll && $past(coll)
       && $stable(l_addr) && $stable(r_addr))
      |-> ($stable(l_busy_n_out) && $stable(r_busy_n_out)));

   assert_busy_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && (!l_busy_n_out || !r_busy_n_out))
      |-> !(l_busy_n_out ? wr_en[1] : wr_en[0]));

   assert_slave_outputs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (l_busy_n_out && r_busy_n_out));

   assert_slave_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && (!l_busy_n_in || !r_busy_n_in))
      |-> !((!l_busy_n_in && wr_en[0]) || (!r_busy_n_in && wr_en[1])));
endmodule

bind dpram_busy_arb dpram_busy_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .master_mode  (master_mode),
   .l_ce         (l_ce),
   .l_addr       (l_addr),
   .l_busy_n_in  (l_busy_n_in),
   .l_busy_n_out (l_busy_n_out),
   .r_ce         (r_ce),
   .r_addr       (r_addr),
   .r_busy_n_in  (r_busy_n_in),
   .r_busy_n_out (r_busy_n_out),
   .wr_en        (wr_en)
);

// File: tb/tb_dpram_busy_arb.sv
`timescale 1ns/1ps
module tb_dpram_busy_arb;
   localparam int AW = 6;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_mode = 1'b0;
   logic          l_ce = 1'b0, l_we = 1'b0, r_ce = 1'b0, r_we = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic          l_busy_n_in = 1'b1, r_busy_n_in = 1'b1;
   logic [DW-1:0] l_rdata, r_rdata;
   logic          l_busy_n_out, r_busy_n_out;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;   // 50 MHz

   dpram_busy_arb #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_busy_n_in(l_busy_n_in), .l_busy_n_out(l_busy_n_out),
      .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_busy_n_in(r_busy_n_in), .r_busy_n_out(r_busy_n_out)
   );

   // behavioural reference state
   logic [DW-1:0] m_mem [1<<AW];
   logic [DW-1:0] m_lrd = '0, m_rrd = '0;
   bit            m_plce = 0, m_prce = 0;
   int            m_pla = 0, m_pra = 0;
   int            m_loser = 0;   // 0 none, 1 left, 2 right

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one cycle: starts just after a falling edge, ends at the next one
   task automatic step(string tag, bit m, bit lce, bit lwe, int la, int lwd,
                       bit rce, bit rwe, int ra, int rwd, bit lbi, bit rbi);
      bit coll, lh, rh, lw, rw;
      int loser;
      master_mode = m;
      l_ce = lce; l_we = lwe; l_addr = AW'(la); l_wdata = DW'(lwd);
      r_ce = rce; r_we = rwe; r_addr = AW'(ra); r_wdata = DW'(rwd);
      l_busy_n_in = lbi; r_busy_n_in = rbi;
      #2;
      coll = lce && rce && (la == ra);
      lh = m_plce && (m_pla == la);
      rh = m_prce && (m_pra == ra);
      if (!coll) loser = 0;
      else if (lh && rh) loser = (m_loser == 0) ? 2 : m_loser;
      else if (lh) loser = 2;
      else if (rh) loser = 1;
      else loser = 2;
      chk(tag, "l_busy_n_out", int'(l_busy_n_out), m ? int'(loser != 1) : 1);
      chk(tag, "r_busy_n_out", int'(r_busy_n_out), m ? int'(loser != 2) : 1);
      chk(tag, "l_rdata", int'(l_rdata), int'(m_lrd));
      chk(tag, "r_rdata", int'(r_rdata), int'(m_rrd));
      lw = lce && lwe && (m ? (loser != 1) : lbi);
      rw = rce && rwe && (m ? (loser != 2) : rbi);
      if (lce) m_lrd = m_mem[la];
      if (rce) m_rrd = m_mem[ra];
      if (rw) m_mem[ra] = DW'(rwd);
      if (lw) m_mem[la] = DW'(lwd);
      m_loser = loser; m_plce = lce; m_prce = rce; m_pla = la; m_pra = ra;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(string tag, bit m);
      step(tag, m, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "l_busy_n_out", int'(l_busy_n_out), 1);
      chk("R1", "r_busy_n_out", int'(r_busy_n_out), 1);
      chk("R1", "l_rdata", int'(l_rdata), 0);
      chk("R1", "r_rdata", int'(r_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R1", 0);

      // R7: slave mode, normal writes with inhibits high
      step("R7", 0, 1, 1, 5, 8'h11, 1, 1, 6, 8'h22, 1, 1);
      // R7: inhibited writes leave words unchanged; collision gives no busy
      step("R7", 0, 1, 1, 5, 8'hEE, 1, 1, 6, 8'hDD, 0, 0);
      step("R7", 0, 1, 0, 5, 0, 1, 0, 5, 0, 1, 1);
      step("R7", 0, 1, 0, 6, 0, 1, 0, 6, 0, 1, 1);
      idle("R7", 0);
      chk("R7", "word5 after inhibit", int'(m_mem[5]), 8'h11);
      // R10: slave same-word double write, left stored
      step("R10", 0, 1, 1, 9, 8'hA1, 1, 1, 9, 8'hB2, 1, 1);
      step("R10", 0, 1, 0, 9, 0, 0, 0, 0, 0, 1, 1);
      idle("R10", 0);
      chk("R10", "l_rdata word9", int'(l_rdata), 8'hA1);

      // R2 / R8: master, distinct addresses, concurrent writes and reads
      step("R2", 1, 1, 1, 10, 8'h3C, 1, 1, 11, 8'h4D, 1, 1);
      step("R8", 1, 1, 0, 11, 0, 1, 0, 10, 0, 1, 1);
      idle("R8", 1);
      chk("R8", "r_rdata word10", int'(r_rdata), 8'h3C);
      // R4 / R6: same-cycle arrival with two writes
      step("R4", 1, 1, 1, 12, 8'h55, 1, 1, 12, 8'h66, 1, 1);
      idle("R6", 1);
      step("R6", 1, 0, 0, 0, 0, 1, 0, 12, 0, 1, 1);
      idle("R6", 1);
      chk("R6", "word12 winner data", int'(r_rdata), 8'h55);
      // R3: read-only collision still raises busy
      step("R3", 1, 1, 0, 12, 0, 1, 0, 12, 0, 1, 1);
      idle("R3", 1);
      // R5: left parks, right arrives late and loses
      step("R5", 1, 1, 0, 20, 0, 0, 0, 0, 0, 1, 1);
      step("R5", 1, 1, 1, 20, 8'h71, 1, 1, 20, 8'h72, 1, 1);
      step("R5", 1, 1, 0, 20, 0, 1, 1, 20, 8'h73, 1, 1);
      // left leaves, right now holds; left returns late and loses
      step("R5", 1, 0, 0, 0, 0, 1, 0, 20, 0, 1, 1);
      step("R6", 1, 1, 1, 20, 8'h99, 1, 0, 20, 0, 1, 1);
      step("R5", 1, 1, 1, 20, 8'h98, 1, 0, 20, 0, 1, 1);
      idle("R6", 1);
      chk("R6", "word20 kept", int'(m_mem[20]), 8'h71);
      // R8: read of a word written in the same cycle returns old data
      step("R8", 1, 1, 1, 30, 8'h5A, 1, 0, 31, 0, 1, 1);
      step("R8", 1, 1, 1, 30, 8'hA5, 1, 0, 30, 0, 1, 1);
      idle("R8", 1);
      // R9: disabled side holds read data, no busy
      step("R9", 1, 0, 1, 30, 8'hFF, 1, 0, 30, 0, 1, 1);
      step("R9", 1, 0, 0, 30, 0, 0, 0, 0, 0, 1, 1);
      idle("R9", 1);

      // randomised traffic on four words, both modes
      for (int n = 0; n < 1200; n++) begin
         bit m;
         m = (n < 800) ? 1'b1 : 1'b0;
         step(m ? "R5" : "R7", m,
              bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
              bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
              bit'($urandom_range(0, 2) != 0), bit'($urandom_range(0, 2) != 0));
      end
      // read back the four words through both sides
      for (int a = 0; a < 4; a++) step("R6", 1, 1, 0, a, 0, 1, 0, 3 - a, 0, 1, 1);
      idle("R8", 1);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule